// File: doc/BRIEF.md
# ADC Calibration Mode Sequencer

This block sits beside a sigma-delta converter core and orders its calibration work. Software writes a two-bit mode code into a setup register. When the filter-sync bit in that same write is clear, a nonzero code starts one of three sequences: a self-calibration, a system zero-scale calibration or a system full-scale calibration. Each phase is timed in output-data periods, which arrive as a one-clock tick from the filter. The mode code clears itself when the calibration part of a sequence ends. The core then runs one conversion, and after that the block returns to free-running conversion.

While a sequence runs, the block steers the converter's input mux. In self-calibration the inputs are first shorted, which gives the zero-scale point. The reference divided by the gain is then applied, which gives full scale. In system calibration the external input stays selected, because the user supplies the zero or full-scale level. The block gives a one-clock offset-capture or gain-capture strobe at the end of the matching phase, so the coefficient logic can latch its result. The zero point is the midscale of the transfer function in bipolar mode and the lower endpoint in unipolar mode. The strobes are the same in both cases. The block drives the active-low data-ready line. The line goes high for the length of a calibration and falls when a fresh result is ready. If the line is low when a command is written, it rises only at the next modulator-cycle tick.

Top module: `adc_cal_seq`

## Requirements
- R1: After reset, drdy_n is 1, mode_bits is 00, in_sel is 00 (external input), busy is 0 and both capture strobes are 0.
- R2: A write with cfg_sync = 0 loads cfg_mode into mode_bits, seen on the next cycle. Code 01 starts self-calibration, 10 starts system zero-scale calibration and 11 starts system full-scale calibration, and each sets busy to 1. Code 00 selects normal conversion.
- R3: A write with cfg_sync = 1 has no effect. mode_bits, in_sel, busy and drdy_n keep their values.
- R4: In self-calibration, in_sel is 01 (inputs shorted) until the 3rd rate tick after the command. It is then 10 (reference over gain) until the 6th tick, and 00 after that.
- R5: In self-calibration, mode_bits returns to 00 after the 6th rate tick. busy drops to 0 and drdy_n goes to 0 after the 9th tick.
- R6: In system calibration (10 or 11), in_sel stays 00. mode_bits returns to 00 after the 3rd rate tick. busy drops to 0 and drdy_n goes to 0 after the 4th tick.
- R7: ofs_cap is a one-clock pulse in the cycle after the 3rd rate tick of self-calibration or of system zero-scale calibration. gain_cap is a one-clock pulse after the 6th tick of self-calibration and after the 3rd tick of system full-scale calibration. The two never pulse together.
- R8: If drdy_n is 1 when a command is written, it stays 1 until the sequence finishes. conv_done pulses during a sequence do not pull it low.
- R9: If drdy_n is 0 when a calibration command is written, it stays 0 until the first mod_tick after the write cycle. It is 1 from the cycle after that tick.
- R10: A nonzero command during a sequence restarts the timing from tick 0 of the newly requested mode. A 00 command during a sequence returns to normal at once, with busy 0, mode_bits 00 and in_sel 00.
- R11: When idle, a conv_done pulse makes drdy_n 0 on the next cycle, and rate ticks have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Setup register write strobe |
| cfg_mode | input | 2 | Mode code carried by the write |
| cfg_sync | input | 1 | Filter-sync bit carried by the write; 1 blocks the command |
| rate_tick | input | 1 | One-clock pulse per output-data period |
| mod_tick | input | 1 | One-clock pulse per modulator cycle |
| conv_done | input | 1 | Conversion result written to the data register |
| mode_bits | output | 2 | Current mode code, cleared when calibration ends |
| in_sel | output | 2 | Input mux select: 00 external, 01 shorted, 10 reference over gain |
| busy | output | 1 | A calibration or its following conversion is in progress |
| ofs_cap | output | 1 | Offset coefficient capture strobe |
| gain_cap | output | 1 | Gain coefficient capture strobe |
| drdy_n | output | 1 | Active-low data ready |

## Verification
The assertions take two things for granted. First, a write and a rate tick never fall in the same cycle. Second, a modulator tick always arrives before a calibration ends, so a delayed rise of data-ready cannot overlap the final fall. The stimulus separates every strobe by at least one clock. It pulses mod_tick only to complete a pending rise, before any rate tick of the new sequence. It aborts with a 00 code only while data-ready is already high. Within those limits, mode codes, tick spacing, points of abort, stray conv_done pulses and blocked sync writes are drawn at random.

// File: rtl/adc_cal_seq.sv
module adc_cal_seq #(
  parameter int SELF_ZERO_PER = 3,
  parameter int SELF_FULL_PER = 3,
  parameter int SELF_CONV_PER = 3,
  parameter int SYS_CAL_PER   = 3,
  parameter int SYS_CONV_PER  = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [1:0] cfg_mode,
  input  logic       cfg_sync,
  input  logic       rate_tick,
  input  logic       mod_tick,
  input  logic       conv_done,
  output logic [1:0] mode_bits,
  output logic [1:0] in_sel,
  output logic       busy,
  output logic       ofs_cap,
  output logic       gain_cap,
  output logic       drdy_n
);

  localparam int M_A  = SELF_ZERO_PER > SELF_FULL_PER ? SELF_ZERO_PER : SELF_FULL_PER;
  localparam int M_B  = SELF_CONV_PER > SYS_CAL_PER ? SELF_CONV_PER : SYS_CAL_PER;
  localparam int M_C  = M_A > M_B ? M_A : M_B;
  localparam int MAXP = M_C > SYS_CONV_PER ? M_C : SYS_CONV_PER;
  localparam int CW   = MAXP < 2 ? 1 : $clog2(MAXP);

  localparam logic [1:0] SEL_EXT  = 2'b00;
  localparam logic [1:0] SEL_ZERO = 2'b01;
  localparam logic [1:0] SEL_REF  = 2'b10;

  typedef enum logic [2:0] {
    S_NORM, S_SZERO, S_SFULL, S_YZERO, S_YFULL, S_CONV
  } state_t;

  state_t        st;
  logic [CW-1:0] cnt;
  logic          conv_self;
  logic          pend;
  int            plen;

  wire cmd      = cfg_wr && !cfg_sync;
  wire rise_now = pend && mod_tick;
  wire last     = int'(cnt) == plen - 1;

  always_comb begin
    case (st)
      S_SZERO: plen = SELF_ZERO_PER;
      S_SFULL: plen = SELF_FULL_PER;
      S_YZERO,
      S_YFULL: plen = SYS_CAL_PER;
      S_CONV:  plen = conv_self ? SELF_CONV_PER : SYS_CONV_PER;
      default: plen = 1;
    endcase
  end

  assign busy   = st != S_NORM;
  assign in_sel = st == S_SZERO ? SEL_ZERO : st == S_SFULL ? SEL_REF : SEL_EXT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_NORM;
      cnt       <= '0;
      conv_self <= 1'b0;
      pend      <= 1'b0;
      mode_bits <= 2'b00;
      drdy_n    <= 1'b1;
      ofs_cap   <= 1'b0;
      gain_cap  <= 1'b0;
    end else begin
      ofs_cap  <= 1'b0;
      gain_cap <= 1'b0;
      if (rise_now) begin
        drdy_n <= 1'b1;
        pend   <= 1'b0;
      end
      if (cmd) begin
        cnt       <= '0;
        mode_bits <= cfg_mode;
        case (cfg_mode)
          2'b01:   st <= S_SZERO;
          2'b10:   st <= S_YZERO;
          2'b11:   st <= S_YFULL;
          default: st <= S_NORM;
        endcase
        if (cfg_mode != 2'b00 && !drdy_n && !rise_now)
          pend <= 1'b1;
      end else if (busy && rate_tick) begin
        if (!last) begin
          cnt <= cnt + 1'b1;
        end else begin
          cnt <= '0;
          case (st)
            S_SZERO: begin
              st      <= S_SFULL;
              ofs_cap <= 1'b1;
            end
            S_SFULL: begin
              st        <= S_CONV;
              conv_self <= 1'b1;
              gain_cap  <= 1'b1;
              mode_bits <= 2'b00;
            end
            S_YZERO: begin
              st        <= S_CONV;
              conv_self <= 1'b0;
              ofs_cap   <= 1'b1;
              mode_bits <= 2'b00;
            end
            S_YFULL: begin
              st        <= S_CONV;
              conv_self <= 1'b0;
              gain_cap  <= 1'b1;
              mode_bits <= 2'b00;
            end
            default: begin
              st     <= S_NORM;
              drdy_n <= 1'b0;
              pend   <= 1'b0;
            end
          endcase
        end
      end else if (!busy && conv_done) begin
        drdy_n <= 1'b0;
        pend   <= 1'b0;
      end
    end
  end

  a_r2_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && !cfg_sync |=> mode_bits == $past(cfg_mode));

  a_r3_sync_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && cfg_sync && !rate_tick |=> $stable(mode_bits) && $stable(busy));

  a_r4_sel_legal: assert property (@(posedge clk) disable iff (!rst_n)
    in_sel != 2'b11);

  a_r5_done_drdy: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && !$past(cfg_wr) |-> !drdy_n && mode_bits == 2'b00);

  a_r6_sys_ext: assert property (@(posedge clk) disable iff (!rst_n)
    mode_bits[1] |-> in_sel == SEL_EXT);

  a_r7_ofs_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ofs_cap |=> !ofs_cap);

  a_r7_gain_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    gain_cap |=> !gain_cap);

  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ofs_cap && gain_cap));

  a_r8_no_fall_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !$fell(drdy_n));

  a_r9_rise_on_mod: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drdy_n) |-> $past(mod_tick));

endmodule

// File: tb/sim_adc_cal_seq.sv
`timescale 1ns/1ps
module sim_adc_cal_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0, cfg_sync = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic rate_tick = 1'b0, mod_tick = 1'b0, conv_done = 1'b0;
  logic [1:0] mode_bits, in_sel;
  logic busy, ofs_cap, gain_cap, drdy_n;

  int checks = 0;
  int fails = 0;
  bit drdy_low = 1'b0;

  always #2.5 clk = ~clk;

  adc_cal_seq u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
    .cfg_sync(cfg_sync), .rate_tick(rate_tick), .mod_tick(mod_tick),
    .conv_done(conv_done), .mode_bits(mode_bits), .in_sel(in_sel),
    .busy(busy), .ofs_cap(ofs_cap), .gain_cap(gain_cap), .drdy_n(drdy_n)
  );

  function automatic int e_len(int m);
    return m == 1 ? 9 : 4;
  endfunction
  function automatic int e_sel(int m, int k);
    if (m != 1) return 0;
    return k < 3 ? 1 : k < 6 ? 2 : 0;
  endfunction
  function automatic int e_mode(int m, int k);
    if (m == 1) return k < 6 ? 1 : 0;
    return k < 3 ? m : 0;
  endfunction
  function automatic int e_busy(int m, int k);
    return k < e_len(m) ? 1 : 0;
  endfunction
  function automatic int e_ofs(int m, int k);
    return ((m == 1 || m == 2) && k == 3) ? 1 : 0;
  endfunction
  function automatic int e_gain(int m, int k);
    return ((m == 1 && k == 6) || (m == 3 && k == 3)) ? 1 : 0;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_wr(int m, bit s);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_mode = 2'(m); cfg_sync = s;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_sync = 1'b0;
  endtask

  task automatic rtick();
    @(negedge clk); rate_tick = 1'b1;
    @(negedge clk); rate_tick = 1'b0;
  endtask

  task automatic mtick();
    @(negedge clk); mod_tick = 1'b1;
    @(negedge clk); mod_tick = 1'b0;
  endtask

  task automatic cdone();
    @(negedge clk); conv_done = 1'b1;
    @(negedge clk); conv_done = 1'b0;
  endtask

  task automatic start(int m);
    bit was_low;
    was_low = drdy_low;
    pulse_wr(m, 1'b0);
    chk("R2 mode_bits", int'(mode_bits), m);
    chk("R2 busy", int'(busy), 1);
    chk("R10 restart phase", int'(in_sel), e_sel(m, 0));
    if (was_low) begin
      chk("R9 drdy held low at write", int'(drdy_n), 0);
      idle($urandom_range(0, 4));
      chk("R9 drdy low before mod tick", int'(drdy_n), 0);
      mtick();
      chk("R9 drdy rises after mod tick", int'(drdy_n), 1);
    end else begin
      chk("R8 drdy stays high", int'(drdy_n), 1);
    end
    drdy_low = 1'b0;
  endtask

  task automatic step(int m, int k);
    string t;
    t = m == 1 ? "R5" : "R6";
    idle($urandom_range(0, 3));
    if ($urandom_range(0, 5) == 0) begin
      cdone();
      chk("R8 conv_done ignored while busy", int'(drdy_n), 1);
    end
    rtick();
    chk(m == 1 ? "R4 in_sel" : "R6 in_sel", int'(in_sel), e_sel(m, k));
    chk({t, " mode_bits"}, int'(mode_bits), e_mode(m, k));
    chk({t, " busy"}, int'(busy), e_busy(m, k));
    chk({t, " drdy_n"}, int'(drdy_n), e_busy(m, k));
    chk("R7 ofs_cap", int'(ofs_cap), e_ofs(m, k));
    chk("R7 gain_cap", int'(gain_cap), e_gain(m, k));
    if (e_ofs(m, k) + e_gain(m, k) != 0) begin
      idle(1);
      chk("R7 ofs_cap one cycle", int'(ofs_cap), 0);
      chk("R7 gain_cap one cycle", int'(gain_cap), 0);
    end
    if (e_busy(m, k) == 0) drdy_low = 1'b1;
  endtask

  task automatic run_full(int m);
    start(m);
    for (int k = 1; k <= e_len(m); k++) step(m, k);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    idle(4);
    rst_n = 1'b1;
    idle(1);
    chk("R1 drdy_n", int'(drdy_n), 1);
    chk("R1 mode_bits", int'(mode_bits), 0);
    chk("R1 in_sel", int'(in_sel), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 strobes", int'(ofs_cap) + int'(gain_cap), 0);

    rtick();
    chk("R11 rate tick ignored idle busy", int'(busy), 0);
    chk("R11 rate tick ignored idle drdy", int'(drdy_n), 1);
    cdone();
    chk("R11 conv_done lowers drdy", int'(drdy_n), 0);
    drdy_low = 1'b1;

    pulse_wr(3, 1'b1);
    chk("R3 sync write mode_bits", int'(mode_bits), 0);
    chk("R3 sync write busy", int'(busy), 0);
    chk("R3 sync write in_sel", int'(in_sel), 0);
    chk("R3 sync write drdy_n", int'(drdy_n), 0);

    run_full(1);
    run_full(2);
    run_full(3);

    start(1);
    step(1, 1);
    step(1, 2);
    run_full(3);

    start(2);
    step(2, 1);
    pulse_wr(0, 1'b0);
    chk("R10 abort busy", int'(busy), 0);
    chk("R10 abort mode_bits", int'(mode_bits), 0);
    chk("R10 abort in_sel", int'(in_sel), 0);
    chk("R10 abort drdy_n", int'(drdy_n), 1);
    cdone();
    chk("R11 conv_done after abort", int'(drdy_n), 0);
    drdy_low = 1'b1;

    for (int i = 0; i < 60; i++) begin
      int m, ab;
      m = $urandom_range(1, 3);
      start(m);
      ab = ($urandom_range(0, 3) == 0) ? $urandom_range(1, e_len(m) - 1) : 0;
      for (int k = 1; k <= e_len(m); k++) begin
        if (k == ab) break;
        step(m, k);
        if (k < e_len(m) && $urandom_range(0, 4) == 0) begin
          pulse_wr($urandom_range(0, 3), 1'b1);
          chk("R3 sync write mid-sequence mode", int'(mode_bits), e_mode(m, k));
          chk("R3 sync write mid-sequence sel", int'(in_sel), e_sel(m, k));
          chk("R3 sync write mid-sequence busy", int'(busy), 1);
        end
      end
      if (ab != 0 && $urandom_range(0, 1) == 0) begin
        pulse_wr(0, 1'b0);
        chk("R10 abort to normal busy", int'(busy), 0);
        chk("R10 abort to normal mode", int'(mode_bits), 0);
        chk("R10 abort to normal drdy", int'(drdy_n), 1);
        cdone();
        chk("R11 conv_done idle", int'(drdy_n), 0);
        drdy_low = 1'b1;
      end
    end

    idle(2);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule